// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a parameterized set of hardware lines and from eight flags that software sets and clears. It picks one request to present to the processor. Each source owns a fixed 9-bit vector number and a 4-bit priority register. The controller compares the best pending priority against a current-priority register. It raises a single request line only when the best pending priority is strictly above the current priority.

Software services an interrupt through a small register port. A read of the acknowledge register returns the winning vector. The same read saves the running current priority on a 15-entry LIFO and makes the winner's priority the new current priority. A write to the end-of-interrupt register restores the saved value. This lets higher-priority interrupts nest inside lower ones. Software can also write the current priority directly. Raising it to the ceiling of a shared resource blocks every interrupt that uses that resource until the old value is written back.

Software flags own vectors 0 to 7. Hardware line i owns vector 8+i. The register map has these word addresses: 0 is current priority, 1 is acknowledge, 2 is end-of-interrupt, 3 is the software flags, and 16+v is the priority of vector v.

Top module: `prio_vec_intc`

## Requirements
- R1: Software flag k (k = 0..7) requests with vector k, and hardware line i requests with vector 8+i. The vector is returned in read data bits [8:0], with the upper bits zero.
- R2: Each source has a 4-bit priority, read and written in bits [3:0] at address 16+vector. A pending source whose priority is 0 never raises the request line.
- R3: irqOut is high exactly when some pending source has a priority strictly greater than the current priority.
- R4: The winner is the pending source with the highest priority. Among pending sources with equal priority, the lowest vector number wins.
- R5: A write to address 3 sets the software flags selected by data bits [7:0] and clears those selected by bits [15:8]. If both a set bit and a clear bit select the same flag, the flag ends up clear. A read of address 3 returns the flags in bits [7:0].
- R6: A read of address 1 while irqOut is high returns the winning vector. On that clock edge the old current priority is pushed onto the LIFO and the winner's priority becomes the current priority.
- R7: A read of address 1 while irqOut is low returns 0x01FF and changes no state.
- R8: A write to address 2 pops the LIFO into the current priority. When the LIFO is empty, the write is ignored.
- R9: The LIFO holds 15 entries. An acknowledge while the LIFO is full does not push or disturb stored entries, but it still loads the winner's priority as the current priority.
- R10: A write to address 0 loads data bits [3:0] as the current priority and leaves the LIFO untouched. Sources at or below the new level are masked.
- R11: After reset the current priority, all source priorities and all software flags are 0, the LIFO is empty, and irqOut is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Register word address |
| rdEn | input | 1 | Read strobe; read data is valid in the same cycle, and side effects take place on the clock edge |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, zero when rdEn is low |
| hwReq | input | NUM_HW | Level-sensitive hardware request lines |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume a single-master register port, where rdEn and wrEn are never high in the same cycle. Under that assumption, an acknowledge, an end-of-interrupt and a current-priority write can never act on the same edge, and one assertion checks the assumption itself. The bench drives every access from one task that raises only one strobe at a time. It changes the hardware lines only between accesses, so every stack and current-priority property sees one cause per edge.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int SW_SRC  = 8;
  localparam int PRI_W   = 4;
  localparam int VEC_W   = 9;
  localparam int DATA_W  = 16;
  localparam logic [VEC_W-1:0] NO_VECTOR = 9'h1FF;

  localparam int REG_CUR      = 0;
  localparam int REG_ACK      = 1;
  localparam int REG_EOI      = 2;
  localparam int REG_SOFT     = 3;
  localparam int REG_PRI_BASE = 16;

  typedef logic [PRI_W-1:0] prio_t;

  typedef struct packed {
    logic curWr;
    logic ackTake;
    logic eoiPop;
    logic softWr;
    logic priWr;
  } ctrl_strobe_t;
endpackage

// File: rtl/intc_arb.sv
`timescale 1ns/1ps
module intc_arb
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] pend,
  input  prio_t              priVals [NUM_SRC],
  output logic               winValid,
  output prio_t              winPri,
  output logic [VEC_W-1:0]   winIdx
);
  localparam int LVL    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LEAVES = 1 << LVL;

  logic             nodeValid [1:2*LEAVES-1];
  prio_t            nodePri   [1:2*LEAVES-1];
  logic [VEC_W-1:0] nodeIdx   [1:2*LEAVES-1];

  // Leaves: one per source, padding leaves never valid
  for (genvar g = 0; g < LEAVES; g++) begin : gLeaf
    if (g < NUM_SRC) begin : gReal
      assign nodeValid[LEAVES+g] = pend[g];
      assign nodePri[LEAVES+g]   = priVals[g];
      assign nodeIdx[LEAVES+g]   = VEC_W'(g);
    end else begin : gPad
      assign nodeValid[LEAVES+g] = 1'b0;
      assign nodePri[LEAVES+g]   = '0;
      assign nodeIdx[LEAVES+g]   = '0;
    end
  end

  // Tournament: left subtree holds lower vectors, so it keeps ties
  for (genvar k = 1; k < LEAVES; k++) begin : gNode
    logic takeLeft;
    assign takeLeft = nodeValid[2*k] &&
                      (!nodeValid[2*k+1] || (nodePri[2*k] >= nodePri[2*k+1]));
    assign nodeValid[k] = nodeValid[2*k] || nodeValid[2*k+1];
    assign nodePri[k]   = takeLeft ? nodePri[2*k] : nodePri[2*k+1];
    assign nodeIdx[k]   = takeLeft ? nodeIdx[2*k] : nodeIdx[2*k+1];
  end

  assign winValid = nodeValid[1];
  assign winPri   = nodePri[1];
  assign winIdx   = nodeIdx[1];
endmodule

// File: rtl/intc_datapath.sv
`timescale 1ns/1ps
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_HW    = 24,
  parameter int STK_DEPTH = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strb,
  input  logic [VEC_W-1:0]   priIdx,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_HW-1:0]  hwReq,
  output logic               irq,
  output logic [VEC_W-1:0]   winVec,
  output prio_t              curPri,
  output logic [SW_SRC-1:0]  softPend,
  output prio_t              priRdVal
);
  localparam int NUM_SRC = NUM_HW + SW_SRC;
  localparam int CNT_W   = $clog2(STK_DEPTH + 1);

  prio_t              priReg   [NUM_SRC];
  prio_t              stackMem [STK_DEPTH];
  logic [CNT_W-1:0]   stkCnt;
  logic [NUM_SRC-1:0] pend;
  logic               winValid;
  prio_t              winPri;
  prio_t              topVal;
  logic               stkFull;
  logic               stkEmpty;

  assign pend     = {hwReq, softPend};
  assign stkFull  = (stkCnt == CNT_W'(STK_DEPTH));
  assign stkEmpty = (stkCnt == '0);

  intc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend    (pend),
    .priVals (priReg),
    .winValid(winValid),
    .winPri  (winPri),
    .winIdx  (winVec)
  );

  assign irq = winValid && (winPri > curPri);

  // Priority registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) priReg[i] <= '0;
    end else if (strb.priWr) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (priIdx == VEC_W'(i)) priReg[i] <= wrData[PRI_W-1:0];
    end
  end

  always_comb begin
    priRdVal = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (priIdx == VEC_W'(i)) priRdVal = priReg[i];
  end

  // Software flags: clear has precedence over set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) softPend <= '0;
    else if (strb.softWr)
      softPend <= (softPend | wrData[SW_SRC-1:0]) & ~wrData[2*SW_SRC-1:SW_SRC];
  end

  // Top of the priority LIFO
  always_comb begin
    topVal = '0;
    for (int i = 0; i < STK_DEPTH; i++)
      if (stkCnt == CNT_W'(i + 1)) topVal = stackMem[i];
  end

  // Current priority and LIFO
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPri <= '0;
      stkCnt <= '0;
      for (int i = 0; i < STK_DEPTH; i++) stackMem[i] <= '0;
    end else if (strb.ackTake) begin
      curPri <= winPri;
      if (!stkFull) begin
        for (int i = 0; i < STK_DEPTH; i++)
          if (stkCnt == CNT_W'(i)) stackMem[i] <= curPri;
        stkCnt <= stkCnt + 1'b1;
      end
    end else if (strb.eoiPop) begin
      if (!stkEmpty) begin
        curPri <= topVal;
        stkCnt <= stkCnt - 1'b1;
      end
    end else if (strb.curWr) begin
      curPri <= wrData[PRI_W-1:0];
    end
  end

  AST_ACK_LOADS_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |=> (curPri == $past(winPri))); // R6
  AST_EOI_RESTORES_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiPop && !stkEmpty) |=> (curPri == $past(topVal))); // R8
  AST_EOI_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiPop && stkEmpty) |=> ($stable(curPri) && stkEmpty)); // R8
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackTake && stkFull) |=> stkFull); // R9
  AST_SOFT_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.softWr |=> ((softPend & $past(wrData[2*SW_SRC-1:SW_SRC])) == '0)); // R5
  AST_ZERO_PRI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (winPri != '0)); // R2
  AST_CUR_WRITE_KEEPS_STACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.curWr |=> $stable(stkCnt)); // R10
endmodule

// File: rtl/intc_ctrl.sv
`timescale 1ns/1ps
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              irq,
  input  logic [VEC_W-1:0]  winVec,
  input  prio_t             curPri,
  input  logic [SW_SRC-1:0] softPend,
  input  prio_t             priRdVal,
  output ctrl_strobe_t      strb,
  output logic [VEC_W-1:0]  priIdx,
  output logic [DATA_W-1:0] rdData
);
  int unsigned addrVal;
  logic        isPri;

  assign addrVal = 32'(regAddr);
  assign isPri   = (addrVal >= REG_PRI_BASE) && (addrVal < REG_PRI_BASE + NUM_SRC);
  assign priIdx  = isPri ? VEC_W'(addrVal - REG_PRI_BASE) : '0;

  always_comb begin
    strb         = '0;
    strb.curWr   = wrEn && (addrVal == REG_CUR);
    strb.eoiPop  = wrEn && (addrVal == REG_EOI);
    strb.softWr  = wrEn && (addrVal == REG_SOFT);
    strb.priWr   = wrEn && isPri;
    strb.ackTake = rdEn && (addrVal == REG_ACK) && irq;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addrVal == REG_CUR)       rdData = DATA_W'(curPri);
      else if (addrVal == REG_ACK)  rdData = DATA_W'(irq ? winVec : NO_VECTOR);
      else if (addrVal == REG_SOFT) rdData = DATA_W'(softPend);
      else if (isPri)               rdData = DATA_W'(priRdVal);
    end
  end

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn)); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R8
endmodule

// File: rtl/prio_vec_intc.sv
`timescale 1ns/1ps
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter  int NUM_HW    = 24,
  parameter  int STK_DEPTH = 15,
  localparam int NUM_SRC   = NUM_HW + 8,
  localparam int ADDR_W    = $clog2(NUM_SRC + 16)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic [NUM_HW-1:0] hwReq,
  output logic              irqOut
);
  ctrl_strobe_t     strb;
  logic [VEC_W-1:0] priIdx;
  logic [VEC_W-1:0] winVec;
  prio_t            curPri;
  prio_t            priRdVal;
  logic [SW_SRC-1:0] softPend;

  intc_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .irq     (irqOut),
    .winVec  (winVec),
    .curPri  (curPri),
    .softPend(softPend),
    .priRdVal(priRdVal),
    .strb    (strb),
    .priIdx  (priIdx),
    .rdData  (rdData)
  );

  intc_datapath #(.NUM_HW(NUM_HW), .STK_DEPTH(STK_DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .priIdx  (priIdx),
    .wrData  (wrData),
    .hwReq   (hwReq),
    .irq     (irqOut),
    .winVec  (winVec),
    .curPri  (curPri),
    .softPend(softPend),
    .priRdVal(priRdVal)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irqOut); // R11
endmodule

// File: tb/prio_vec_intc_bench.sv
`timescale 1ns/1ps
module prio_vec_intc_bench;
  localparam int NUM_HW  = 24;
  localparam int STK     = 15;
  localparam int NUM_SRC = NUM_HW + 8;
  localparam int ADDR_W  = $clog2(NUM_SRC + 16);

  logic clk = 0;
  logic rstN = 0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic rdEn = 0, wrEn = 0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [NUM_HW-1:0] hwReq = '0;
  logic irqOut;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model state
  int     mPri[NUM_SRC];
  bit [7:0] mSoft;
  int     mCur;
  int     mStk[$];

  always #5 clk = ~clk;

  prio_vec_intc #(.NUM_HW(NUM_HW), .STK_DEPTH(STK)) u_prio_vec_intc (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .hwReq(hwReq), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pendOf(int v);
    if (v < 8) return mSoft[v];
    return hwReq[v-8];
  endfunction

  function automatic void modelWin(output int idx, output int bp);
    idx = -1; bp = -1;
    for (int v = 0; v < NUM_SRC; v++)
      if (pendOf(v) && mPri[v] > bp) begin idx = v; bp = mPri[v]; end
  endfunction

  // kind: 0 idle, 1 read, 2 write
  task automatic busOp(input int kind, input int addr, input int data, input string tag);
    int wIdx, wPri, expRd;
    bit expIrq;
    regAddr = ADDR_W'(addr);
    rdEn    = (kind == 1);
    wrEn    = (kind == 2);
    wrData  = 16'(data);
    #2;
    modelWin(wIdx, wPri);
    expIrq = (wIdx >= 0) && (wPri > mCur);
    check(irqOut === expIrq, "R3", int'(irqOut), int'(expIrq));
    if (kind == 1) begin
      expRd = 0;
      if (addr == 0) expRd = mCur;
      else if (addr == 1) expRd = expIrq ? wIdx : 'h1FF;
      else if (addr == 3) expRd = mSoft;
      else if (addr >= 16 && addr < 16 + NUM_SRC) expRd = mPri[addr-16];
      check(rdData === 16'(expRd), tag, int'(rdData), expRd);
    end
    @(posedge clk);
    if (kind == 1 && addr == 1 && expIrq) begin
      if (mStk.size() < STK) mStk.push_back(mCur);
      mCur = wPri;
    end else if (kind == 2) begin
      if (addr == 0) mCur = data & 15;
      else if (addr == 2) begin
        if (mStk.size() > 0) mCur = mStk.pop_back();
      end else if (addr == 3) mSoft = (mSoft | 8'(data)) & ~8'(data >> 8);
      else if (addr >= 16 && addr < 16 + NUM_SRC) mPri[addr-16] = data & 15;
    end
    @(negedge clk);
    rdEn = 0; wrEn = 0;
  endtask

  task automatic setPri(input int v, input int p);
    busOp(2, 16 + v, p, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_SRC; i++) mPri[i] = 0;
    mSoft = 0; mCur = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R11 reset state
    busOp(1, 0, 0, "R11");
    busOp(1, 3, 0, "R11");
    busOp(1, 16 + 20, 0, "R11");
    busOp(1, 1, 0, "R7");

    // R2 zero priority never requests; R1 hardware vector numbering
    hwReq[3] = 1'b1;
    busOp(0, 0, 0, "R2");
    setPri(11, 5);
    busOp(1, 16 + 11, 0, "R2");
    busOp(1, 1, 0, "R1");          // vector 11, cur -> 5
    busOp(1, 0, 0, "R6");
    hwReq[5] = 1'b1;               // vector 13
    setPri(13, 5);                 // equal priority masked
    busOp(0, 0, 0, "R10");
    setPri(13, 7);
    busOp(1, 1, 0, "R6");          // nested: vector 13, cur -> 7
    busOp(1, 0, 0, "R6");
    busOp(2, 2, 0, "R8");          // back to 5
    busOp(1, 0, 0, "R8");
    busOp(2, 2, 0, "R8");          // back to 0
    busOp(2, 2, 0, "R8");          // empty: ignored
    busOp(1, 0, 0, "R8");
    hwReq = '0;

    // R4 tie-break and R5 software flags
    setPri(2, 9); setPri(6, 9);
    busOp(2, 3, 'h0044, "R5");
    busOp(1, 3, 0, "R5");
    busOp(1, 1, 0, "R4");          // vector 2 wins tie
    busOp(2, 2, 0, "R8");
    busOp(2, 3, 'h0404, "R5");     // set and clear bit 2: clear wins
    busOp(1, 3, 0, "R5");
    busOp(1, 1, 0, "R4");          // vector 6 now
    busOp(2, 2, 0, "R8");

    // R10 current priority masking
    busOp(2, 0, 10, "R10");
    busOp(1, 1, 0, "R7");          // masked -> 0x1FF
    busOp(2, 0, 9, "R10");
    busOp(1, 1, 0, "R7");
    busOp(2, 0, 8, "R10");
    busOp(1, 1, 0, "R10");
    busOp(2, 2, 0, "R8");
    busOp(1, 0, 0, "R8");
    busOp(2, 3, 'hFF00, "R5");
    busOp(2, 0, 0, "R10");

    // R9 fill and overflow the LIFO
    setPri(30, 15);
    hwReq[22] = 1'b1;
    for (int k = 0; k < 15; k++) begin
      busOp(2, 0, k, "R10");
      busOp(1, 1, 0, "R9");
    end
    busOp(2, 0, 3, "R10");
    busOp(1, 1, 0, "R9");          // full: no push, cur -> 15
    busOp(1, 0, 0, "R9");
    for (int k = 0; k < 17; k++) begin
      busOp(2, 2, 0, "R9");
      busOp(1, 0, 0, "R9");
    end
    hwReq = '0;

    // Mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(0, 7);
      if (sel == 0) hwReq = NUM_HW'($urandom());
      case (sel)
        1: setPri($urandom_range(0, NUM_SRC - 1), $urandom_range(0, 15));
        2: busOp(2, 3, $urandom_range(0, 'hFFFF), "R5");
        3: busOp(2, 0, $urandom_range(0, 15), "R10");
        4, 5: busOp(1, 1, 0, "R6");
        6: busOp(2, 2, 0, "R8");
        7: busOp(1, 16 + $urandom_range(0, NUM_SRC - 1), 0, "R2");
        default: busOp(1, 0, 0, "R4");
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule